// File: doc/BRIEF.md
# Split-Tag Direct-Mapped Translation Cache

This block caches address translations for a processor's fast path. It is direct-mapped. Each index holds one shared offset word and three tags, one for each access kind: instruction fetch, data load and data store. Because each kind has its own tag, a page can be usable for loads without being usable for stores or fetches. The walker may therefore fill a kind only after that kind's permission has been checked. The stored offset is the physical address minus the virtual address. A hit returns the physical address by adding that offset to the incoming virtual address, so the in-page bits pass through unchanged.

Lookup is purely combinational. Refills are written on the next rising clock edge. A single-cycle flush invalidates everything. A per-kind trigger-watch enable marks a refilled tag so that later fast-path lookups of that kind miss. This sends every such access to the slow path, where debug triggers can be evaluated.

The design has no state machine. The three tag arrays share one generated structure, and they keep their state only in the array registers.

Top module: `xlate_cache`

## Requirements
- R1: While reset is asserted, and after it is released, every tag of every kind is invalid, and no lookup of any kind hits until a refill is made.
- R2: The access kind codes are 0 = fetch, 1 = load, 2 = store and 3 = none. The virtual page number is `va[VA_W-1:PAGE_SHIFT]`. The index is that page number modulo ENTRIES (its low bits). A lookup hits only when the tag at that index, in the array of its own kind, holds the full page number with the watch flag clear. A different page that maps to the same index misses.
- R3: On a hit, `lk_pa` equals `lk_va` plus the offset `rf_pa - rf_va` saved by the most recent refill of that index, of any kind, taken modulo 2^VA_W.
- R4: A refill writes only the tag array of its own kind. A sibling-kind tag at that index that holds the same page number keeps hitting, and it returns the newly written offset.
- R5: On a refill, each sibling-kind tag at that index whose page number differs from the new one is set to all-ones (invalid). The watch flag is not taken into account in this comparison.
- R6: If the watch enable for the refilling kind is high, the stored tag has its top bit (the watch flag) set. Lookups of that kind then miss until a later refill is made without the flag. The flag does not affect how sibling tags are compared in R5.
- R7: A flush sets every tag of all three kinds to all-ones on the next edge. A lookup in the same cycle as a flush misses. A refill in the same cycle as a flush is discarded.
- R8: A lookup with kind 3 never hits. A refill with kind 3 changes no tag and no offset.
- R9: A refill takes effect on the next rising edge. A lookup of the refilled address in the same cycle as the refill still sees the old contents.
- R10: A refill leaves the tags and offsets at every other index unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| flush | input | 1 | Invalidate all tags |
| lk_va | input | VA_W | Lookup virtual address |
| lk_kind | input | 2 | Lookup access kind |
| lk_hit | output | 1 | Lookup hit |
| lk_pa | output | VA_W | Translated physical address, valid with lk_hit |
| rf_en | input | 1 | Refill request |
| rf_kind | input | 2 | Refill access kind |
| rf_va | input | VA_W | Refill virtual address |
| rf_pa | input | VA_W | Refill physical address |
| watch_fetch | input | 1 | Flag fetch refills for slow-path trigger checks |
| watch_load | input | 1 | Flag load refills for slow-path trigger checks |
| watch_store | input | 1 | Flag store refills for slow-path trigger checks |

## Verification
The checker assumes three things about the inputs. `rf_en` and `flush` are low while reset is held. ENTRIES is a power of two. Every input changes away from the rising edge, so the value sampled at an edge is the value the refill and flush logic used. The bench drives all stimulus on the falling edge and holds the request lines low through reset. It keeps the kinds to the four defined codes, and it chooses page numbers so that index aliasing and shared-page sibling cases occur on purpose.

// File: rtl/xc_pkg.sv
package xc_pkg;
    typedef enum logic [1:0] {
        ACC_FETCH = 2'd0,
        ACC_LOAD  = 2'd1,
        ACC_STORE = 2'd2,
        ACC_NONE  = 2'd3
    } acc_e;

    localparam int NUM_KINDS = 3;
endpackage

// File: rtl/xc_tag_array.sv
module xc_tag_array #(
    parameter  int ENTRIES = 256,
    parameter  int VPN_W   = 52,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int TAG_W   = VPN_W + 1
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            flush,
    input  logic                            wr_sel,
    input  logic                            own,
    input  logic                            watch,
    input  logic [IDX_W-1:0]                wr_idx,
    input  logic [VPN_W-1:0]                wr_vpn,
    output logic [ENTRIES-1:0][TAG_W-1:0]   tags_o
);
    // top bit is the watch flag; all-ones means invalid
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tags_o <= '1;
        end else if (flush) begin
            tags_o <= '1;
        end else if (wr_sel) begin
            if (own) begin
                tags_o[wr_idx] <= {watch, wr_vpn};
            end else if (tags_o[wr_idx][VPN_W-1:0] != wr_vpn) begin
                tags_o[wr_idx] <= '1;
            end
        end
    end
endmodule

// File: rtl/xc_offset_ram.sv
module xc_offset_ram #(
    parameter  int ENTRIES = 256,
    parameter  int VA_W    = 64,
    localparam int IDX_W   = $clog2(ENTRIES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [VA_W-1:0]  wr_va,
    input  logic [VA_W-1:0]  wr_pa,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [VA_W-1:0]  rd_offs
);
    logic [ENTRIES-1:0][VA_W-1:0] offs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            offs_q <= '0;
        end else if (wr_sel) begin
            offs_q[wr_idx] <= wr_pa - wr_va;
        end
    end

    always_comb begin
        rd_offs = offs_q[rd_idx];
    end
endmodule

// File: rtl/xc_probe.sv
module xc_probe
    import xc_pkg::*;
#(
    parameter  int VA_W  = 64,
    parameter  int VPN_W = 52,
    localparam int TAG_W = VPN_W + 1
) (
    input  logic                            flush,
    input  logic [1:0]                      kind,
    input  logic [VPN_W-1:0]                vpn,
    input  logic [VA_W-1:0]                 va,
    input  logic [NUM_KINDS-1:0][TAG_W-1:0] tags,
    input  logic [VA_W-1:0]                 offs,
    output logic                            hit,
    output logic [VA_W-1:0]                 pa
);
    logic [NUM_KINDS-1:0] match;

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_cmp
        assign match[g] = (kind == 2'(g)) && (tags[g] == {1'b0, vpn});
    end

    always_comb begin
        hit = (|match) && !flush;
        pa  = va + offs;
    end
endmodule

// File: rtl/xlate_cache.sv
module xlate_cache
    import xc_pkg::*;
#(
    parameter  int VA_W       = 64,
    parameter  int PAGE_SHIFT = 12,
    parameter  int ENTRIES    = 256,
    localparam int VPN_W      = VA_W - PAGE_SHIFT,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int TAG_W      = VPN_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            flush,
    input  logic [VA_W-1:0] lk_va,
    input  logic [1:0]      lk_kind,
    output logic            lk_hit,
    output logic [VA_W-1:0] lk_pa,
    input  logic            rf_en,
    input  logic [1:0]      rf_kind,
    input  logic [VA_W-1:0] rf_va,
    input  logic [VA_W-1:0] rf_pa,
    input  logic            watch_fetch,
    input  logic            watch_load,
    input  logic            watch_store
);
    logic [VPN_W-1:0] lk_vpn, rf_vpn;
    logic [IDX_W-1:0] lk_idx, rf_idx;
    logic             rf_sel;
    logic [NUM_KINDS-1:0] watch_v;
    logic [NUM_KINDS-1:0][ENTRIES-1:0][TAG_W-1:0] tag_all;
    logic [NUM_KINDS-1:0][TAG_W-1:0] lk_tags;
    logic [VA_W-1:0] lk_offs;

    always_comb begin
        lk_vpn  = lk_va[VA_W-1:PAGE_SHIFT];
        rf_vpn  = rf_va[VA_W-1:PAGE_SHIFT];
        lk_idx  = lk_vpn[IDX_W-1:0];
        rf_idx  = rf_vpn[IDX_W-1:0];
        rf_sel  = rf_en && (rf_kind != ACC_NONE) && !flush;
        watch_v = {watch_store, watch_load, watch_fetch};
    end

    for (genvar g = 0; g < NUM_KINDS; g++) begin : g_kind
        xc_tag_array #(
            .ENTRIES (ENTRIES),
            .VPN_W   (VPN_W)
        ) tags_i (
            .clk    (clk),
            .rst_n  (rst_n),
            .flush  (flush),
            .wr_sel (rf_sel),
            .own    (rf_kind == 2'(g)),
            .watch  (watch_v[g]),
            .wr_idx (rf_idx),
            .wr_vpn (rf_vpn),
            .tags_o (tag_all[g])
        );
        assign lk_tags[g] = tag_all[g][lk_idx];
    end

    xc_offset_ram #(
        .ENTRIES (ENTRIES),
        .VA_W    (VA_W)
    ) offs_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_sel  (rf_sel),
        .wr_idx  (rf_idx),
        .wr_va   (rf_va),
        .wr_pa   (rf_pa),
        .rd_idx  (lk_idx),
        .rd_offs (lk_offs)
    );

    xc_probe #(
        .VA_W  (VA_W),
        .VPN_W (VPN_W)
    ) probe_i (
        .flush (flush),
        .kind  (lk_kind),
        .vpn   (lk_vpn),
        .va    (lk_va),
        .tags  (lk_tags),
        .offs  (lk_offs),
        .hit   (lk_hit),
        .pa    (lk_pa)
    );
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
    parameter  int VA_W       = 64,
    parameter  int PAGE_SHIFT = 12,
    parameter  int ENTRIES    = 256,
    localparam int VPN_W      = VA_W - PAGE_SHIFT,
    localparam int IDX_W      = $clog2(ENTRIES),
    localparam int TAG_W      = VPN_W + 1
) (
    input logic                              clk,
    input logic                              rst_n,
    input logic                              flush,
    input logic [1:0]                        lk_kind,
    input logic                              lk_hit,
    input logic                              rf_en,
    input logic [1:0]                        rf_kind,
    input logic [VA_W-1:0]                   rf_va,
    input logic [2:0]                        watch_v,
    input logic [2:0][ENTRIES-1:0][TAG_W-1:0] tag_all
);
    logic [VPN_W-1:0] c_vpn;
    logic [IDX_W-1:0] c_idx;
    assign c_vpn = rf_va[VA_W-1:PAGE_SHIFT];
    assign c_idx = c_vpn[IDX_W-1:0];

    // R7
    flush_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |-> !lk_hit);

    // R8
    none_miss_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_kind == 2'd3) |-> !lk_hit);

    // R7
    flush_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> ((&tag_all[0][0]) && (&tag_all[1][0]) && (&tag_all[2][0])
                   && (&tag_all[0][ENTRIES-1]) && (&tag_all[1][ENTRIES-1])
                   && (&tag_all[2][ENTRIES-1])));

    // R8
    none_refill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rf_en && rf_kind == 2'd3 && !flush) |=> $stable(tag_all));

    for (genvar g = 0; g < 3; g++) begin : g_k
        // R6
        own_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rf_en && rf_kind == 2'(g) && !flush) |=>
            (tag_all[g][$past(c_idx)] == {$past(watch_v[g]), $past(c_vpn)}));

        // R5
        sibling_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rf_en && rf_kind != 2'(g) && rf_kind != 2'd3 && !flush) |=>
            ((&tag_all[g][$past(c_idx)]) ||
             (tag_all[g][$past(c_idx)][VPN_W-1:0] == $past(c_vpn))));
    end
endmodule

bind xlate_cache xc_checker #(
    .VA_W       (VA_W),
    .PAGE_SHIFT (PAGE_SHIFT),
    .ENTRIES    (ENTRIES)
) chk_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .flush   (flush),
    .lk_kind (lk_kind),
    .lk_hit  (lk_hit),
    .rf_en   (rf_en),
    .rf_kind (rf_kind),
    .rf_va   (rf_va),
    .watch_v ({watch_store, watch_load, watch_fetch}),
    .tag_all (tag_all)
);

// File: tb/xlate_cache_tb_top.sv
module xlate_cache_tb_top;
    localparam int N = 16;
    localparam logic [1:0] KF = 2'd0, KL = 2'd1, KS = 2'd2, KN = 2'd3;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic flush = 1'b0;
    logic [63:0] lk_va = '0;
    logic [1:0]  lk_kind = KN;
    logic        lk_hit;
    logic [63:0] lk_pa;
    logic        rf_en = 1'b0;
    logic [1:0]  rf_kind = KN;
    logic [63:0] rf_va = '0, rf_pa = '0;
    logic        watch_fetch = 1'b0, watch_load = 1'b0, watch_store = 1'b0;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    xlate_cache #(.ENTRIES(N)) dut_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .lk_va(lk_va), .lk_kind(lk_kind), .lk_hit(lk_hit), .lk_pa(lk_pa),
        .rf_en(rf_en), .rf_kind(rf_kind), .rf_va(rf_va), .rf_pa(rf_pa),
        .watch_fetch(watch_fetch), .watch_load(watch_load), .watch_store(watch_store)
    );

    function automatic logic [63:0] va_of(int i, int alt);
        return 64'(i + N * (i + 7 + alt * 40)) << 12;
    endfunction

    function automatic logic [63:0] off_of(int i, int alt);
        return 64'h0000_0040_0000_0000 + (64'(i * 5 + alt) << 12);
    endfunction

    task automatic chk(input string tag, input bit exp_hit, input logic [63:0] exp_pa);
        checks++;
        if (lk_hit !== exp_hit || (exp_hit && lk_pa !== exp_pa)) begin
            fails++;
            $display("FAIL %s: hit=%0d pa=%h expected hit=%0d pa=%h",
                     tag, lk_hit, lk_pa, exp_hit, exp_pa);
        end
    endtask

    task automatic look(input logic [1:0] k, input logic [63:0] va,
                        input bit exp_hit, input logic [63:0] exp_pa, input string tag);
        @(negedge clk);
        lk_kind = k;
        lk_va   = va;
        #2;
        chk(tag, exp_hit, exp_pa);
    endtask

    task automatic refill(input logic [1:0] k, input logic [63:0] va,
                          input logic [63:0] pa, input bit w);
        @(negedge clk);
        rf_en = 1'b1; rf_kind = k; rf_va = va; rf_pa = pa;
        watch_fetch = w && k == KF;
        watch_load  = w && k == KL;
        watch_store = w && k == KS;
        @(posedge clk);
        #1;
        rf_en = 1'b0;
        watch_fetch = 1'b0; watch_load = 1'b0; watch_store = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: hit=%0d pa=%h expected hit=0 pa=0", lk_hit, lk_pa);
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [63:0] a;
        repeat (3) @(posedge clk);
        // R1: reset state, every kind misses
        for (int i = 0; i < N; i += 5) begin
            look(KF, va_of(i, 0), 1'b0, '0, "R1 fetch after reset");
            look(KL, va_of(i, 0), 1'b0, '0, "R1 load after reset");
            look(KS, va_of(i, 0), 1'b0, '0, "R1 store after reset");
        end
        @(negedge clk);
        rst_n = 1'b1;
        look(KL, va_of(1, 0), 1'b0, '0, "R1 load after release");

        // sweep: load refill at every index
        for (int i = 0; i < N; i++) refill(KL, va_of(i, 0), va_of(i, 0) + off_of(i, 0), 1'b0);
        for (int i = 0; i < N; i++) begin
            a = va_of(i, 0) | 64'hABC;
            look(KL, a, 1'b1, a + off_of(i, 0), "R2 R3 load hit");
            look(KF, a, 1'b0, '0, "R4 fetch not written");
            look(KL, va_of(i, 1) | 64'h123, 1'b0, '0, "R2 alias miss");
        end

        // R4: fetch refill same page idx3, shared offset
        refill(KF, va_of(3, 0), va_of(3, 0) + off_of(3, 1), 1'b0);
        look(KF, va_of(3, 0) | 64'h10, 1'b1, (va_of(3, 0) | 64'h10) + off_of(3, 1), "R4 fetch hit");
        look(KL, va_of(3, 0) | 64'h20, 1'b1, (va_of(3, 0) | 64'h20) + off_of(3, 1), "R4 load keeps tag, new offset");

        // R5: store refill different page idx3
        refill(KS, va_of(3, 1), va_of(3, 1) + off_of(3, 2), 1'b0);
        look(KL, va_of(3, 0), 1'b0, '0, "R5 load sibling invalidated");
        look(KF, va_of(3, 0), 1'b0, '0, "R5 fetch sibling invalidated");
        look(KS, va_of(3, 1) | 64'hFFF, 1'b1, (va_of(3, 1) | 64'hFFF) + off_of(3, 2), "R5 store hit");
        // R10: neighbours untouched
        look(KL, va_of(4, 0), 1'b1, va_of(4, 0) + off_of(4, 0), "R10 index 4 kept");
        look(KL, va_of(2, 0), 1'b1, va_of(2, 0) + off_of(2, 0), "R10 index 2 kept");

        // R9: same-cycle lookup sees old contents
        @(negedge clk);
        rf_en = 1'b1; rf_kind = KS; rf_va = va_of(2, 0); rf_pa = va_of(2, 0) + off_of(2, 0);
        lk_kind = KS; lk_va = va_of(2, 0) | 64'h44;
        #2;
        chk("R9 before edge", 1'b0, '0);
        @(posedge clk);
        #1;
        rf_en = 1'b0;
        #2;
        chk("R9 after edge", 1'b1, (va_of(2, 0) | 64'h44) + off_of(2, 0));

        // R6: watch flag on store refill
        refill(KS, va_of(5, 0), va_of(5, 0) + off_of(5, 2), 1'b1);
        look(KS, va_of(5, 0), 1'b0, '0, "R6 watched store misses");
        look(KL, va_of(5, 0), 1'b1, va_of(5, 0) + off_of(5, 2), "R6 load sibling still hits");
        refill(KS, va_of(5, 0), va_of(5, 0) + off_of(5, 2), 1'b0);
        look(KS, va_of(5, 0), 1'b1, va_of(5, 0) + off_of(5, 2), "R6 unwatched store hits");

        // R8: kind none
        look(KN, va_of(6, 0), 1'b0, '0, "R8 none lookup misses");
        refill(KN, va_of(6, 1), va_of(6, 1) + off_of(6, 3), 1'b0);
        look(KL, va_of(6, 0), 1'b1, va_of(6, 0) + off_of(6, 0), "R8 none refill ignored");

        // R7: flush with same-cycle lookup and refill
        @(negedge clk);
        flush = 1'b1;
        rf_en = 1'b1; rf_kind = KL; rf_va = va_of(9, 2); rf_pa = va_of(9, 2) + off_of(9, 0);
        lk_kind = KL; lk_va = va_of(0, 0);
        #2;
        chk("R7 lookup during flush", 1'b0, '0);
        @(posedge clk);
        #1;
        flush = 1'b0; rf_en = 1'b0;
        for (int i = 0; i < N; i++) begin
            look(KL, va_of(i, 0), 1'b0, '0, "R7 load flushed");
            look(KS, va_of(i, 0), 1'b0, '0, "R7 store flushed");
        end
        look(KL, va_of(9, 2), 1'b0, '0, "R7 refill during flush discarded");
        look(KS, va_of(3, 1), 1'b0, '0, "R7 store idx3 flushed");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule